// File: doc/BRIEF.md
# Three-Bank Pin Controller with Per-Pin Interrupts

This block gives software control over ninety general-purpose pins, split into three banks of thirty. Each bank has its own set of 32-bit registers: pin direction, pad drive enable, output value, sampled input value, and a per-pin interrupt unit. Software configures each interrupt as level or edge, picks the active polarity, unmasks it, and acknowledges it. All registers sit in one small window on a simple register port. Reads return data in the same cycle. A write takes effect at the clock edge that samples it.

Registers are grouped by function. Within a group, the three banks follow one another every four bytes. Each bank raises its own interrupt line whenever at least one of its pins is configured as an input, has a pending status bit and is unmasked. Pad inputs pass through a two-flop synchronizer before anything else sees them. Software emulates a trigger on both edges by flipping the polarity bit after each event.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every direction bit is 1 (input), and the polarity, type, enable, pin-enable and output registers are 0. All interrupt lines and all pad output enables are low.
- R2: The register address is group offset + 4 × bank, with bank in 0..2. The group offsets are: direction 0x00, polarity 0x20, type 0x30, enable 0x40, status 0x50, pin enable 0x60, input data 0x70, output data 0x80. Bits 31:30 of every register read as 0, and writing one bank leaves the other banks unchanged.
- R3: A pad drives (output enable high) only when its direction bit is 0 and its pin-enable bit is 1. The pad output value is the output-data bit.
- R4: The input-data register returns the pad level two clock edges after the pad changes, through a two-flop synchronizer.
- R5: In edge mode (type bit 1), a status bit sets on the cycle after the synchronized level changes to the polarity value (1 = rising, 0 = falling). It then stays set until it is acknowledged, so the interrupt rises three edges after the pad change.
- R6: In level mode (type bit 0), a status bit is set every cycle while the synchronized level equals the polarity value (1 = high, 0 = low). An acknowledge made while the level is still active leaves the bit set.
- R7: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. If a new event arrives in the same cycle as the acknowledge, the event wins. Status bits never clear without a status write.
- R8: Bank b's interrupt line irq[b] is the OR over its pins of (direction = 1) AND status AND enable. A pending pin that is masked or configured as output does not raise the line.
- R9: A read from an unused offset, a missing bank, 0x90 or above, or an address not aligned to 4 bytes returns 0. A write there changes nothing, and writes to the input-data group are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| pad_in | input | 90 | Pad input levels, bank b pin p at bit 30b+p |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| irq | output | 3 | One interrupt line per bank |

## Verification
Read data is due in the same cycle as the read strobe, and register writes show up on the next read. The input-data register follows a pad change after two edges. A pending interrupt appears on irq three edges after the triggering pad change, and one edge after a write to enable, direction or status. Each expectation is queued with the cycle in which it falls due, and the monitor compares it at the falling edge of that cycle. The bench also checks the cycle just before each deadline, so a result that arrives one cycle early or late is caught.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
  localparam int ADDR_W  = 8;
  localparam int GRP_LSB = 4;
  localparam int BNK_LSB = 2;
  // register groups, selected by address bits 7:4
  localparam logic [3:0] GRP_DIR  = 4'h0;
  localparam logic [3:0] GRP_POL  = 4'h2;
  localparam logic [3:0] GRP_TYPE = 4'h3;
  localparam logic [3:0] GRP_EN   = 4'h4;
  localparam logic [3:0] GRP_STS  = 4'h5;
  localparam logic [3:0] GRP_PEN  = 4'h6;
  localparam logic [3:0] GRP_DIN  = 4'h7;
  localparam logic [3:0] GRP_DOUT = 4'h8;
endpackage

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
module gpb_sync #(
  parameter int W = 90
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpb_bank.sv
`timescale 1ns/1ps
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int PINS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_grp,
  input  logic [PINS-1:0] wr_data,
  input  logic [PINS-1:0] pin_lvl,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] pol_q,
  output logic [PINS-1:0] type_q,
  output logic [PINS-1:0] en_q,
  output logic [PINS-1:0] sts_q,
  output logic [PINS-1:0] pen_q,
  output logic [PINS-1:0] dout_q,
  output logic            irq
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] dir_d, pol_d, type_d, en_d, sts_d, pen_d, dout_d;
  logic [PINS-1:0] ack_mask, active, hit;

  // next state
  always_comb begin
    dir_d    = dir_q;
    pol_d    = pol_q;
    type_d   = type_q;
    en_d     = en_q;
    pen_d    = pen_q;
    dout_d   = dout_q;
    ack_mask = '1;
    if (wr_en) begin
      case (wr_grp)
        GRP_DIR:  dir_d    = wr_data;
        GRP_POL:  pol_d    = wr_data;
        GRP_TYPE: type_d   = wr_data;
        GRP_EN:   en_d     = wr_data;
        GRP_STS:  ack_mask = wr_data;
        GRP_PEN:  pen_d    = wr_data;
        GRP_DOUT: dout_d   = wr_data;
        default:  ;
      endcase
    end
    // level matches polarity; edge mode additionally needs a change
    active = ~(pin_lvl ^ pol_q);
    hit    = active & (~type_q | (pin_lvl ^ prev_q));
    sts_d  = (sts_q & ack_mask) | hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      type_q <= '0;
      en_q   <= '0;
      sts_q  <= '0;
      pen_q  <= '0;
      dout_q <= '0;
      prev_q <= '0;
    end else begin
      dir_q  <= dir_d;
      pol_q  <= pol_d;
      type_q <= type_d;
      en_q   <= en_d;
      sts_q  <= sts_d;
      pen_q  <= pen_d;
      dout_q <= dout_d;
      prev_q <= pin_lvl;
    end
  end

  assign irq = |(dir_q & sts_q & en_q);
endmodule

// File: rtl/pinbank_gpio.sv
`timescale 1ns/1ps
module pinbank_gpio
  import gpb_pkg::*;
#(
  parameter int NBANKS = 3,
  parameter int PINS   = 30,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NBANKS*PINS-1:0] pad_in,
  output logic [NBANKS*PINS-1:0] pad_out,
  output logic [NBANKS*PINS-1:0] pad_oe,
  output logic [NBANKS-1:0]      irq
);
  localparam int NPADS = NBANKS * PINS;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_core_n <= rs1_q;
    end
  end

  // address decode
  logic [3:0]        grp;
  logic [1:0]        bnk;
  logic              addr_ok;
  logic [NBANKS-1:0] wr_bank;
  logic              unused_wdata;

  assign grp     = bus_addr[GRP_LSB +: 4];
  assign bnk     = bus_addr[BNK_LSB +: 2];
  assign addr_ok = (bus_addr[1:0] == 2'b00) && (grp <= GRP_DOUT) &&
                   (grp != 4'h1) && (int'(bnk) < NBANKS);
  assign unused_wdata = ^bus_wdata[DW-1:PINS];

  // pad input synchronizer
  logic [NPADS-1:0] pin_sync;
  gpb_sync #(.W(NPADS)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  logic [PINS-1:0]  dir_b [NBANKS];
  logic [PINS-1:0]  pol_b [NBANKS];
  logic [PINS-1:0]  type_b[NBANKS];
  logic [PINS-1:0]  en_b  [NBANKS];
  logic [PINS-1:0]  sts_b [NBANKS];
  logic [PINS-1:0]  pen_b [NBANKS];
  logic [PINS-1:0]  dout_b[NBANKS];
  logic [NPADS-1:0] sts_all, pen_all;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign wr_bank[b] = bus_sel && bus_we && addr_ok && (int'(bnk) == b);

    gpb_bank #(.PINS(PINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (wr_bank[b]),
      .wr_grp  (grp),
      .wr_data (bus_wdata[PINS-1:0]),
      .pin_lvl (pin_sync[b*PINS +: PINS]),
      .dir_q   (dir_b[b]),
      .pol_q   (pol_b[b]),
      .type_q  (type_b[b]),
      .en_q    (en_b[b]),
      .sts_q   (sts_b[b]),
      .pen_q   (pen_b[b]),
      .dout_q  (dout_b[b]),
      .irq     (irq[b])
    );

    assign pad_out[b*PINS +: PINS] = dout_b[b];
    assign pad_oe [b*PINS +: PINS] = ~dir_b[b] & pen_b[b];
    assign sts_all[b*PINS +: PINS] = sts_b[b];
    assign pen_all[b*PINS +: PINS] = pen_b[b];
  end

  // read mux, same-cycle
  logic [PINS-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (bus_sel && !bus_we && addr_ok) begin
      for (int b = 0; b < NBANKS; b++) begin
        if (int'(bnk) == b) begin
          case (grp)
            GRP_DIR:  rd_val = dir_b[b];
            GRP_POL:  rd_val = pol_b[b];
            GRP_TYPE: rd_val = type_b[b];
            GRP_EN:   rd_val = en_b[b];
            GRP_STS:  rd_val = sts_b[b];
            GRP_PEN:  rd_val = pen_b[b];
            GRP_DIN:  rd_val = pin_sync[b*PINS +: PINS];
            GRP_DOUT: rd_val = dout_b[b];
            default:  rd_val = '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = {{(DW-PINS){1'b0}}, rd_val};
endmodule

// File: rtl/gpb_checker.sv
`timescale 1ns/1ps
module gpb_checker #(
  parameter int PINS  = 30,
  parameter int NPADS = 90,
  parameter int NB    = 3,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPADS-1:0] pad_in,
  input logic [NPADS-1:0] pad_oe,
  input logic [NB-1:0]    irq,
  input logic [NPADS-1:0] sts_all,
  input logic [NPADS-1:0] pen_all,
  input logic [NPADS-1:0] din_all
);
  logic [1:0] age_q;
  logic       sts_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign sts_wr = bus_sel && bus_we && (bus_addr[7:4] == 4'h5);

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr >= 8'h90) |-> (bus_rdata == '0)); // R9
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> (bus_rdata[DW-1:PINS] == '0)); // R2
  AST_OE_NEEDS_PINEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~pen_all) == '0)); // R3
  AST_DIN_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (din_all == $past(pad_in, 2))); // R4
  AST_STS_ONLY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_wr) |-> ((~sts_all & $past(sts_all)) == '0)); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (sts_all != '0)); // R8
endmodule

bind pinbank_gpio gpb_checker #(
  .PINS(PINS), .NPADS(NBANKS*PINS), .NB(NBANKS), .DW(DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .sts_all   (sts_all),
  .pen_all   (pen_all),
  .din_all   (pin_sync)
);

// File: tb/pinbank_gpio_test.sv
`timescale 1ns/1ps
module pinbank_gpio_test;
  localparam int NP = 90;
  localparam int K_RD = 0, K_IRQ = 1, K_OE = 2, K_OUT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic [2:0]    irq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  int            q_kind[$];
  logic [NP-1:0] q_exp[$];
  string         q_tag[$];
  int            q_due[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pinbank_gpio uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // monitor: compares queued items in the cycle they fall due
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      int k;
      logic [NP-1:0] e, a;
      string t;
      k = q_kind.pop_front(); e = q_exp.pop_front();
      t = q_tag.pop_front();  void'(q_due.pop_front());
      case (k)
        K_RD:    a = NP'(bus_rdata);
        K_IRQ:   a = NP'(irq);
        K_OE:    a = pad_oe;
        default: a = pad_out;
      endcase
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  function automatic void push(int k, logic [NP-1:0] e, string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t); q_due.push_back(cyc);
  endfunction

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    push(K_RD, NP'(e), t);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic sig(int k, logic [NP-1:0] e, string t);
    push(k, e, t);
    @(posedge clk); #1;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1;
    idle(3);

    // R1 reset state
    rd(8'h00, 32'h3FFF_FFFF, "R1 dir reset");
    rd(8'h44, 32'h0, "R1 enable reset");
    rd(8'h64, 32'h0, "R1 pin enable reset");
    rd(8'h88, 32'h0, "R1 dout reset");
    sig(K_IRQ, '0, "R1 irq reset");
    sig(K_OE, '0, "R1 oe reset");

    // make all pins active-high level, then clear status
    wr(8'h20, 32'h3FFF_FFFF); wr(8'h24, 32'h3FFF_FFFF); wr(8'h28, 32'h3FFF_FFFF);
    wr(8'h50, 0); wr(8'h54, 0); wr(8'h58, 0);
    rd(8'h58, 32'h0, "R7 cleared after ack");

    // R2 map and top bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h3FFF_FFFF, "R2 dir top bits");
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h84, 32'h3FFF_FFFF, "R2 dout top bits");
    wr(8'h84, 0);
    wr(8'h88, 32'h1234_5678);
    rd(8'h88, 32'h1234_5678, "R2 bank2 dout");
    rd(8'h80, 32'h0, "R2 bank0 untouched");

    // R3 pad drive
    wr(8'h00, 32'h3FFF_FFF0);
    wr(8'h80, 32'h5);
    wr(8'h60, 32'h3);
    sig(K_OE, NP'(3), "R3 oe gated by pin enable");
    sig(K_OUT, (NP'(30'h1234_5678) << 60) | NP'(5), "R3 pad out");
    wr(8'h60, 32'hF);
    sig(K_OE, NP'(4'hF), "R3 oe all outputs");
    wr(8'h00, 32'h3FFF_FFFF);
    sig(K_OE, '0, "R3 oe off as input");

    // R4 input synchronizer latency
    pad_in[67] = 1;
    rd(8'h78, 32'h0, "R4 din not yet");
    rd(8'h78, 32'h0, "R4 din one edge");
    rd(8'h78, 32'h80, "R4 din after two edges");
    pad_in[67] = 0;
    idle(3);
    wr(8'h58, 0);

    // R5 rising edge, bank0 pin20
    wr(8'h30, 32'h0010_0000);
    wr(8'h40, 32'h0010_0000);
    pad_in[20] = 1;
    idle(2);
    sig(K_IRQ, '0, "R5 irq not early");
    sig(K_IRQ, NP'(3'b001), "R5 irq on rising edge");
    pad_in[20] = 0;
    idle(3);
    sig(K_IRQ, NP'(3'b001), "R5 status sticky");
    rd(8'h50, 32'h0010_0000, "R5 status bit");

    // R7 acknowledge
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, 32'h0010_0000, "R7 write one keeps");
    wr(8'h50, 32'hFFEF_FFFF);
    rd(8'h50, 32'h0, "R7 write zero clears");
    sig(K_IRQ, '0, "R7 irq drops");

    // R6 level high, bank1 pin5
    wr(8'h44, 32'h20);
    pad_in[35] = 1;
    idle(2);
    sig(K_IRQ, '0, "R6 irq not early");
    sig(K_IRQ, NP'(3'b010), "R6 level irq");
    wr(8'h54, 0);
    rd(8'h54, 32'h20, "R6 ack while active keeps");
    pad_in[35] = 0;
    idle(3);
    sig(K_IRQ, NP'(3'b010), "R6 held until ack");
    wr(8'h54, 0);
    sig(K_IRQ, '0, "R6 irq after ack");
    rd(8'h54, 32'h0, "R6 status cleared");
    wr(8'h44, 0);

    // R8 enable masks, bank0 pin21 edge
    wr(8'h30, 32'h0030_0000);
    pad_in[21] = 1;
    idle(3);
    sig(K_IRQ, '0, "R8 masked pin quiet");
    rd(8'h50, 32'h0020_0000, "R8 masked status set");
    wr(8'h40, 32'h0030_0000);
    sig(K_IRQ, NP'(3'b001), "R8 unmask raises");
    pad_in[21] = 0;
    wr(8'h50, 0);
    sig(K_IRQ, '0, "R8 cleared");

    // R8 direction qualifies, bank2 pin0
    wr(8'h38, 32'h1);
    wr(8'h48, 32'h1);
    wr(8'h08, 32'h3FFF_FFFE);
    sig(K_OE, '0, "R3 no pin enable no drive");
    pad_in[60] = 1;
    idle(3);
    sig(K_IRQ, '0, "R8 output pin quiet");
    rd(8'h58, 32'h1, "R8 status set on output pin");
    wr(8'h08, 32'h3FFF_FFFF);
    sig(K_IRQ, NP'(3'b100), "R8 input pin raises");
    pad_in[60] = 0;
    wr(8'h58, 0);
    sig(K_IRQ, '0, "R8 bank2 cleared");

    // R5 falling edge, bank1 pin9
    wr(8'h34, 32'h200);
    wr(8'h24, 32'h3FFF_FDFF);
    wr(8'h44, 32'h200);
    pad_in[39] = 1;
    idle(3);
    sig(K_IRQ, '0, "R5 rising ignored in falling mode");
    pad_in[39] = 0;
    idle(2);
    sig(K_IRQ, '0, "R5 falling not early");
    sig(K_IRQ, NP'(3'b010), "R5 falling edge");
    wr(8'h54, 0);
    sig(K_IRQ, '0, "R5 falling cleared");

    // R9 unused offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R9 hole reads zero");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0, "R9 missing bank zero");
    rd(8'h00, 32'h3FFF_FFFF, "R9 bank0 dir untouched");
    rd(8'h90, 32'h0, "R9 past end");
    rd(8'hF0, 32'h0, "R9 high offset");
    wr(8'h01, 32'h0);
    rd(8'h02, 32'h0, "R9 misaligned read");
    rd(8'h00, 32'h3FFF_FFFF, "R9 misaligned write ignored");
    pad_in[67] = 1;
    idle(2);
    wr(8'h78, 32'h0);
    rd(8'h78, 32'h80, "R9 din read only");
    pad_in[67] = 0;

    idle(3);
    if (q_due.size() != 0) begin
      failures++;
      $display("FAIL drain: got %0d expected 0", q_due.size());
    end
    if (!done) begin
      done = 1;
      report();
      $finish;
    end
  end
endmodule